// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that walks a chain of transfer descriptors kept in memory. A descriptor is four 32-bit words at a 16-byte aligned address. The engine reads the four words and then moves the requested number of bytes one beat at a time. Each beat is a read at the source followed by a write of the same data at the target. After the last beat the engine either follows the link word to the next descriptor or halts. A link that points back to an earlier descriptor forms a ring, and the engine keeps circling that ring until the run input is dropped.

A rising edge on `run` starts the channel at `startPtr`. The master port carries one request at a time and holds it until the memory acknowledges it. An error flag returned with that acknowledge aborts the channel. A peripheral request input paces transfers whose command word asks for pacing. Three single-cycle event strobes and a `stopped` level feed a status bank. The live source and target addresses are available at all times, so software can work out how many bytes remain.

Top module: `desc_dma_channel`

## Requirements
- R1: After reset `stopped` is 1, `memReq` is 0 and no event strobe is asserted.
- R2: A rising edge of `run` while stopped takes `startPtr[31:4]` as the descriptor base. The engine then issues four 4-byte reads (`memWidth` = 3) at base+0, +4, +8 and +12, which return the link word, the source address, the target address and the command word, in that order.
- R3: Each beat is a read at the source followed by a write of the returned data at the target. Both use the width code from command bits 15:14: 1 = 1 byte, 2 = 2 bytes, 3 = 4 bytes, and 0 is treated as 3. The length in command bits 12:0 drops by the beat size after each beat and stops at zero. A trailing remainder smaller than one beat still costs one full beat. A length of 0 gives no beats.
- R4: When command bit 31 is set, the source advances by the beat size after each beat. When it is clear, the source stays fixed. Command bit 30 does the same for the target. `curSrc` and `curTgt` always show the current addresses.
- R5: When bit 0 of the link word is set, the channel halts after the descriptor. Otherwise it fetches the next descriptor at link bits 31:4, and a link back to an earlier descriptor loops without end.
- R6: Command bit 22 gives a one-cycle `evStart` in the cycle the command word is accepted. Command bit 21 gives one `evEnd` pulse when the descriptor finishes.
- R7: When command bit 29 or bit 28 is set, the engine waits for `periphReq` before the first beat of every burst. The burst size comes from command bits 17:16: 1 = 8 bytes, 2 = 16 bytes, 3 = 32 bytes, and 0 means every beat is its own burst. A transfer with both bits clear never waits.
- R8: While `memReq` is high and `memAck` is low, address, direction, width and write data stay unchanged.
- R9: An acknowledge with `memErr` set pulses `evBusErr`. The channel is stopped in the next cycle and issues no further request, so the beat whose read failed is never written.
- R10: When `run` goes low, the beat in flight completes and the channel stops before the next read, with no `evEnd`. Dropping `run` while waiting for `periphReq` stops the channel at once.
- R11: After a stop, a new rising edge of `run` starts again from `startPtr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel enable; rising edge starts a chain |
| startPtr | input | 32 | Address of the first descriptor |
| periphReq | input | 1 | Peripheral request for paced transfers |
| memReq | output | 1 | Memory request valid |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the access |
| memWidth | output | 2 | Access width code (1, 2 or 3 = 4 bytes) |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with `memAck` |
| memAck | input | 1 | Memory accepts or completes the request |
| memErr | input | 1 | Error response, valid with `memAck` |
| curSrc | output | 32 | Current source address |
| curTgt | output | 32 | Current target address |
| stopped | output | 1 | Channel is halted |
| evStart | output | 1 | Start-of-descriptor event |
| evEnd | output | 1 | End-of-descriptor event |
| evBusErr | output | 1 | Bus error event |

## Verification
The transfer path is run with several descriptor shapes: a plain 4-byte copy that increments both addresses; a two-descriptor chain with 2-byte and 1-byte beats, odd lengths and one address held fixed; a zero-length descriptor followed by one whose width code is 0; and a two-entry ring. Together these tell apart the width decode, the rounding of a partial last beat, the per-side increment flags and the link-versus-stop decision. Running the same copy against a memory that stalls two cycles out of three separates request holding from data flow. The paced descriptor, driven with single request pulses, checks that exactly one burst of beats follows each pulse. Error injection on a later source read, a run drop during a write and a run drop during a request wait each check a different way of stopping early.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  // command word bit positions (software-visible layout)
  localparam int CMD_INC_SRC  = 31;
  localparam int CMD_INC_TGT  = 30;
  localparam int CMD_PACE_SRC = 29;
  localparam int CMD_PACE_TGT = 28;
  localparam int CMD_IRQ_BEG  = 22;
  localparam int CMD_IRQ_FIN  = 21;
  localparam int CMD_BURST_LO = 16;
  localparam int CMD_WIDTH_LO = 14;
  localparam int LINK_HALT    = 0;
  localparam int DESC_ALIGN   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_WAIT, ST_READ, ST_WRITE, ST_DONE
  } chState_t;

  typedef enum logic [1:0] {
    SEL_DESC, SEL_SRC, SEL_TGT
  } addrSel_t;

  typedef struct packed {
    logic       loadStart;
    logic       loadNext;
    logic       capWord;
    logic [1:0] wordIdx;
    logic       capData;
    logic       beatDone;
    addrSel_t   addrSel;
  } dpCtl_t;

  function automatic logic [1:0] effWidth(input logic [1:0] code);
    return (code == 2'd0) ? 2'd3 : code;
  endfunction

  function automatic logic [2:0] widthBytes(input logic [1:0] code);
    case (effWidth(code))
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [5:0] burstBytes(input logic [1:0] code);
    case (code)
      2'd1:    return 6'd8;
      2'd2:    return 6'd16;
      2'd3:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/desc_dma_dp.sv
module desc_dma_dp
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memWidth,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] curSrc,
  output logic [ADDR_W-1:0] curTgt,
  output logic              remZero,
  output logic              paced,
  output logic              burstOpen,
  output logic              haltAfter,
  output logic              finIrq
);

  localparam int PTR_W = ADDR_W - DESC_ALIGN;

  logic [PTR_W-1:0]  descPtr;
  logic [DATA_W-1:0] linkWord;
  logic [ADDR_W-1:0] srcAddr, tgtAddr;
  logic [DATA_W-1:0] cmdWord;
  logic [LEN_W-1:0]  remLen;
  logic [DATA_W-1:0] dataBuf;
  logic [5:0]        burstCnt;

  logic [2:0]        beatB;
  logic [5:0]        burstB;
  logic [6:0]        burstSum;

  assign beatB    = widthBytes(cmdWord[CMD_WIDTH_LO +: 2]);
  assign burstB   = burstBytes(cmdWord[CMD_BURST_LO +: 2]);
  assign burstSum = {1'b0, burstCnt} + 7'(beatB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtr  <= '0;
      linkWord <= '0;
      srcAddr  <= '0;
      tgtAddr  <= '0;
      cmdWord  <= '0;
      remLen   <= '0;
      dataBuf  <= '0;
      burstCnt <= '0;
    end else begin
      if (ctl.loadStart) descPtr <= startPtr[ADDR_W-1:DESC_ALIGN];
      if (ctl.loadNext)  descPtr <= linkWord[ADDR_W-1:DESC_ALIGN];
      if (ctl.capWord) begin
        case (ctl.wordIdx)
          2'd0: linkWord <= rdata;
          2'd1: srcAddr  <= rdata;
          2'd2: tgtAddr  <= rdata;
          default: begin
            cmdWord  <= rdata;
            remLen   <= rdata[LEN_W-1:0];
            burstCnt <= '0;
          end
        endcase
      end
      if (ctl.capData) dataBuf <= rdata;
      if (ctl.beatDone) begin
        remLen <= (remLen > LEN_W'(beatB)) ? remLen - LEN_W'(beatB) : '0;
        if (cmdWord[CMD_INC_SRC]) srcAddr <= srcAddr + ADDR_W'(beatB);
        if (cmdWord[CMD_INC_TGT]) tgtAddr <= tgtAddr + ADDR_W'(beatB);
        if (burstB == 6'd0 || burstSum >= {1'b0, burstB}) burstCnt <= '0;
        else burstCnt <= burstSum[5:0];
      end
    end
  end

  always_comb begin
    case (ctl.addrSel)
      SEL_SRC: memAddr = srcAddr;
      SEL_TGT: memAddr = tgtAddr;
      default: memAddr = {descPtr, ctl.wordIdx, 2'b00};
    endcase
  end

  assign memWidth  = (ctl.addrSel == SEL_DESC) ? 2'd3 : effWidth(cmdWord[CMD_WIDTH_LO +: 2]);
  assign memWdata  = dataBuf;
  assign curSrc    = srcAddr;
  assign curTgt    = tgtAddr;
  assign remZero   = (remLen == '0);
  assign paced     = cmdWord[CMD_PACE_SRC] | cmdWord[CMD_PACE_TGT];
  assign burstOpen = (burstCnt != '0);
  assign haltAfter = linkWord[LINK_HALT];
  assign finIrq    = cmdWord[CMD_IRQ_FIN];

endmodule

// File: rtl/desc_dma_ctl.sv
module desc_dma_ctl
  import desc_dma_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   run,
  input  logic   periphReq,
  input  logic   memAck,
  input  logic   memErr,
  input  logic   begIrqBit,
  input  logic   remZero,
  input  logic   paced,
  input  logic   burstOpen,
  input  logic   haltAfter,
  input  logic   finIrq,
  output dpCtl_t ctl,
  output logic   memReq,
  output logic   memWe,
  output logic   stopped,
  output logic   evStart,
  output logic   evEnd,
  output logic   evBusErr
);

  chState_t   st, stNext;
  logic [1:0] fetchIdx, idxNext;
  logic       runQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st       <= ST_IDLE;
      fetchIdx <= '0;
      runQ     <= 1'b0;
    end else begin
      st       <= stNext;
      fetchIdx <= idxNext;
      runQ     <= run;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.wordIdx = fetchIdx;
    ctl.addrSel = SEL_DESC;
    stNext      = st;
    idxNext     = fetchIdx;
    memReq      = 1'b0;
    memWe       = 1'b0;
    evStart     = 1'b0;
    evEnd       = 1'b0;
    evBusErr    = 1'b0;
    case (st)
      ST_IDLE: begin
        if (run && !runQ) begin
          ctl.loadStart = 1'b1;
          idxNext       = '0;
          stNext        = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          if (memErr) begin
            evBusErr = 1'b1;
            stNext   = ST_IDLE;
          end else begin
            ctl.capWord = 1'b1;
            if (fetchIdx == 2'd3) begin
              evStart = begIrqBit;
              stNext  = ST_CHECK;
            end else begin
              idxNext = fetchIdx + 2'd1;
            end
          end
        end
      end
      ST_CHECK: begin
        if (remZero)                stNext = ST_DONE;
        else if (!run)              stNext = ST_IDLE;
        else if (paced && !burstOpen) stNext = ST_WAIT;
        else                        stNext = ST_READ;
      end
      ST_WAIT: begin
        if (!run)           stNext = ST_IDLE;
        else if (periphReq) stNext = ST_READ;
      end
      ST_READ: begin
        ctl.addrSel = SEL_SRC;
        memReq      = 1'b1;
        if (memAck) begin
          if (memErr) begin
            evBusErr = 1'b1;
            stNext   = ST_IDLE;
          end else begin
            ctl.capData = 1'b1;
            stNext      = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        ctl.addrSel = SEL_TGT;
        memReq      = 1'b1;
        memWe       = 1'b1;
        if (memAck) begin
          if (memErr) begin
            evBusErr = 1'b1;
            stNext   = ST_IDLE;
          end else begin
            ctl.beatDone = 1'b1;
            stNext       = ST_CHECK;
          end
        end
      end
      ST_DONE: begin
        evEnd = finIrq;
        if (haltAfter || !run) begin
          stNext = ST_IDLE;
        end else begin
          ctl.loadNext = 1'b1;
          idxNext      = '0;
          stNext       = ST_FETCH;
        end
      end
      default: stNext = ST_IDLE;
    endcase
  end

  assign stopped = (st == ST_IDLE);

endmodule

// File: rtl/desc_dma_channel.sv
module desc_dma_channel
  import desc_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              run,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic              periphReq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memWidth,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  input  logic              memErr,
  output logic [ADDR_W-1:0] curSrc,
  output logic [ADDR_W-1:0] curTgt,
  output logic              stopped,
  output logic              evStart,
  output logic              evEnd,
  output logic              evBusErr
);

  dpCtl_t ctl;
  logic   remZero, paced, burstOpen, haltAfter, finIrq;

  desc_dma_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .run       (run),
    .periphReq (periphReq),
    .memAck    (memAck),
    .memErr    (memErr),
    .begIrqBit (memRdata[CMD_IRQ_BEG]),
    .remZero   (remZero),
    .paced     (paced),
    .burstOpen (burstOpen),
    .haltAfter (haltAfter),
    .finIrq    (finIrq),
    .ctl       (ctl),
    .memReq    (memReq),
    .memWe     (memWe),
    .stopped   (stopped),
    .evStart   (evStart),
    .evEnd     (evEnd),
    .evBusErr  (evBusErr)
  );

  desc_dma_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .startPtr  (startPtr),
    .rdata     (memRdata),
    .memAddr   (memAddr),
    .memWidth  (memWidth),
    .memWdata  (memWdata),
    .curSrc    (curSrc),
    .curTgt    (curTgt),
    .remZero   (remZero),
    .paced     (paced),
    .burstOpen (burstOpen),
    .haltAfter (haltAfter),
    .finIrq    (finIrq)
  );

endmodule

// File: rtl/desc_dma_channel_chk.sv
module desc_dma_channel_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [1:0]        memWidth,
  input logic [DATA_W-1:0] memWdata,
  input logic              memAck,
  input logic              stopped,
  input logic              evStart,
  input logic              evEnd,
  input logic              evBusErr
);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)
                             && $stable(memWidth) && $stable(memWdata)));

  // R1
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopped |-> (!memReq && !evStart && !evEnd));

  // R9
  buserr_halt_chk: assert property (@(posedge clk) disable iff (!rstN)
    evBusErr |=> stopped);

  // R6
  start_on_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    evStart |-> (memReq && memAck && !memWe && memWidth == 2'd3));

  // R9
  err_needs_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    evBusErr |-> (memReq && memAck));

endmodule

bind desc_dma_channel desc_dma_channel_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/desc_dma_channel_tb.sv
module desc_dma_channel_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        run;
  logic [31:0] startPtr;
  logic        periphReq;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [1:0]  memWidth;
  logic        memAck, memErr;
  logic [31:0] curSrc, curTgt;
  logic        stopped, evStart, evEnd, evBusErr;

  always #5 clk = ~clk;

  desc_dma_channel u_dut (.*);

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  width;
  } txn_t;

  logic [31:0] descMem [256];
  txn_t        expQ [$];
  int nChecks = 0, nFails = 0;
  int startSeen = 0, endSeen = 0, errSeen = 0, wrCount = 0;
  int expStart, expEnd, stallCnt = 0;
  bit stallMode = 0, errEn = 0, dropOnWrite = 0, finished = 0;
  logic [31:0] errAddr = '0;

  function automatic logic [31:0] memModel(input logic [31:0] a);
    if (a < 32'h400) return descMem[a[9:2]];
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mkCmd(input bit incS, incT, paceS, paceT, irqB, irqF,
                                        input int burst, width, len);
    return (32'(incS) << 31) | (32'(incT) << 30) | (32'(paceS) << 29) | (32'(paceT) << 28)
         | (32'(irqB) << 22) | (32'(irqF) << 21) | (32'(burst) << 16) | (32'(width) << 14)
         | 32'(len);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setDesc(input logic [31:0] a, input logic [31:0] lnk, s, t, c);
    descMem[a[9:2]]        = lnk;
    descMem[a[9:2] + 8'd1] = s;
    descMem[a[9:2] + 8'd2] = t;
    descMem[a[9:2] + 8'd3] = c;
  endtask

  // behavioural model: expected transaction list and event counts
  task automatic buildChain(input logic [31:0] ptr, input int maxDesc);
    expStart = 0;
    expEnd   = 0;
    for (int d = 0; d < maxDesc; d++) begin
      logic [31:0] p, lnk, s, t, c;
      int wb, code, rem;
      p   = ptr & ~32'hF;
      lnk = memModel(p); s = memModel(p + 4); t = memModel(p + 8); c = memModel(p + 12);
      for (int k = 0; k < 4; k++) expQ.push_back('{0, p + 32'(4 * k), 32'h0, 2'd3});
      if (c[22]) expStart++;
      code = (c[15:14] == 2'd0) ? 3 : int'(c[15:14]);
      wb   = (code == 1) ? 1 : (code == 2) ? 2 : 4;
      rem  = int'(c[12:0]);
      while (rem > 0) begin
        expQ.push_back('{0, s, 32'h0, 2'(code)});
        expQ.push_back('{1, t, s ^ 32'h5A5A_0000, 2'(code)});
        if (c[31]) s += 32'(wb);
        if (c[30]) t += 32'(wb);
        rem = (rem > wb) ? rem - wb : 0;
      end
      if (c[21]) expEnd++;
      if (lnk[0]) break;
      ptr = lnk;
    end
  endtask

  // memory responder and per-clock comparison against the model
  initial begin
    memAck = 0; memErr = 0; memRdata = '0;
    forever begin
      @(negedge clk);
      memAck = 0; memErr = 0; memRdata = '0;
      if (memReq && rstN) begin
        stallCnt++;
        if (!stallMode || (stallCnt % 3 == 0)) begin
          memAck   = 1;
          memRdata = memWe ? 32'h0 : memModel(memAddr);
          if (errEn && !memWe && memAddr == errAddr) memErr = 1;
          else if (expQ.size() == 0) begin
            chk(0, "R2", "unexpected access", memAddr, 32'h0);
          end else begin
            txn_t e;
            e = expQ.pop_front();
            chk(e.we == memWe && e.addr == memAddr && e.width == memWidth &&
                (!e.we || e.data == memWdata), e.we ? "R3" : "R2",
                "access addr/dir/width/data", memAddr, e.addr);
          end
          if (memWe && !memErr) begin
            wrCount++;
            if (dropOnWrite) begin run = 0; dropOnWrite = 0; end
          end
        end
      end
      #1;
      if (evStart)  startSeen++;
      if (evEnd)    endSeen++;
      if (evBusErr) errSeen++;
    end
  end

  task automatic startRun(input logic [31:0] p);
    @(negedge clk);
    startPtr = p;
    run = 1;
    @(negedge clk);
  endtask

  task automatic waitStopped(input int lim);
    for (int n = 0; n < lim && !stopped; n++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic endRun();
    run = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int s0, e0, w0, b0;
    for (int i = 0; i < 256; i++) descMem[i] = '0;
    rstN = 0; run = 0; startPtr = '0; periphReq = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stopped == 1 && memReq == 0 && !evStart && !evEnd && !evBusErr, "R1", "reset outputs",
        {28'h0, stopped, memReq, evStart, evEnd}, 32'h8);
    rstN = 1;
    @(negedge clk);

    // R2 R3 R4 R6: single descriptor, 4-byte beats, both addresses increment
    setDesc(32'h100, 32'h1, 32'h1000, 32'h2000, mkCmd(1, 1, 0, 0, 1, 1, 0, 3, 12));
    buildChain(32'h100, 4);
    s0 = startSeen; e0 = endSeen;
    startRun(32'h100); waitStopped(200); endRun();
    chk(expQ.size() == 0, "R3", "beats left", expQ.size(), 0);
    chk(startSeen - s0 == expStart, "R6", "start events", startSeen - s0, expStart);
    chk(endSeen - e0 == expEnd, "R6", "end events", endSeen - e0, expEnd);
    chk(curSrc == 32'h100C && curTgt == 32'h200C, "R4", "final source", curSrc, 32'h100C);

    // R5 R3 R4: chain with 2- and 1-byte beats, odd lengths, fixed sides
    setDesc(32'h140, 32'h180, 32'h1100, 32'h2100, mkCmd(1, 0, 0, 0, 0, 0, 0, 2, 5));
    setDesc(32'h180, 32'h1, 32'h1200, 32'h2300, mkCmd(0, 1, 0, 0, 0, 1, 0, 1, 3));
    buildChain(32'h140, 4);
    s0 = startSeen; e0 = endSeen;
    startRun(32'h140); waitStopped(300); endRun();
    chk(expQ.size() == 0, "R5", "chain beats left", expQ.size(), 0);
    chk(endSeen - e0 == 1 && startSeen == s0, "R6", "chain events", endSeen - e0, 1);
    chk(curSrc == 32'h1200 && curTgt == 32'h2303, "R4", "fixed source, moving target", curTgt, 32'h2303);

    // R3: zero length, then width code 0 acting as 4 bytes
    setDesc(32'h1C0, 32'h200, 32'h1400, 32'h2400, mkCmd(1, 1, 0, 0, 0, 1, 0, 3, 0));
    setDesc(32'h200, 32'h1, 32'h1500, 32'h2500, mkCmd(1, 1, 0, 0, 0, 1, 0, 0, 8));
    buildChain(32'h1C0, 4);
    e0 = endSeen; w0 = wrCount;
    startRun(32'h1C0); waitStopped(300); endRun();
    chk(expQ.size() == 0 && wrCount - w0 == 2, "R3", "zero length / width 0 writes", wrCount - w0, 2);
    chk(endSeen - e0 == 2, "R6", "zero length end event", endSeen - e0, 2);

    // R7: paced, 8-byte bursts of 4-byte beats
    setDesc(32'h240, 32'h1, 32'h1600, 32'h2600, mkCmd(1, 1, 1, 0, 0, 1, 1, 3, 16));
    buildChain(32'h240, 4);
    w0 = wrCount;
    startRun(32'h240);
    repeat (20) @(negedge clk);
    chk(wrCount - w0 == 0, "R7", "no beat before request", wrCount - w0, 0);
    periphReq = 1; @(negedge clk); periphReq = 0;
    repeat (20) @(negedge clk);
    chk(wrCount - w0 == 2, "R7", "one burst per request", wrCount - w0, 2);
    periphReq = 1; @(negedge clk); periphReq = 0;
    waitStopped(100);
    chk(wrCount - w0 == 4 && expQ.size() == 0, "R7", "second burst", wrCount - w0, 4);
    endRun();

    // R8: stalling memory
    stallMode = 1;
    buildChain(32'h100, 4);
    startRun(32'h100); waitStopped(600); endRun();
    stallMode = 0;
    chk(expQ.size() == 0 && curSrc == 32'h100C, "R8", "stalled copy", curSrc, 32'h100C);

    // R9: bus error on the second source read
    buildChain(32'h100, 4);
    errEn = 1; errAddr = 32'h1004;
    w0 = wrCount; b0 = errSeen; e0 = endSeen;
    startRun(32'h100); waitStopped(200);
    chk(errSeen - b0 == 1 && stopped, "R9", "error event and halt", errSeen - b0, 1);
    chk(wrCount - w0 == 1 && endSeen == e0, "R9", "failed beat not written", wrCount - w0, 1);
    endRun(); errEn = 0; expQ.delete();

    // R10: run dropped during the first write
    buildChain(32'h100, 4);
    w0 = wrCount; e0 = endSeen;
    dropOnWrite = 1;
    startRun(32'h100); waitStopped(200);
    chk(wrCount - w0 == 1 && stopped, "R10", "stop after current beat", wrCount - w0, 1);
    chk(endSeen == e0 && curSrc == 32'h1004, "R10", "source after partial", curSrc, 32'h1004);
    expQ.delete();

    // R11: restart after stop runs the full chain
    buildChain(32'h100, 4);
    startRun(32'h100); waitStopped(200); endRun();
    chk(expQ.size() == 0 && curTgt == 32'h200C, "R11", "restart full copy", curTgt, 32'h200C);

    // R5: two-entry ring keeps looping until run drops
    setDesc(32'h280, 32'h2C0, 32'h1800, 32'h2800, mkCmd(1, 1, 0, 0, 0, 1, 0, 3, 4));
    setDesc(32'h2C0, 32'h280, 32'h1900, 32'h2900, mkCmd(1, 1, 0, 0, 0, 1, 0, 3, 4));
    buildChain(32'h280, 8);
    e0 = endSeen;
    startRun(32'h280);
    for (int n = 0; n < 400 && endSeen - e0 < 3; n++) @(negedge clk);
    endRun(); waitStopped(50);
    chk(endSeen - e0 >= 3 && stopped, "R5", "ring wrapped", endSeen - e0, 3);
    expQ.delete();

    // R10: run dropped while waiting for the peripheral
    buildChain(32'h240, 4);
    w0 = wrCount;
    startRun(32'h240);
    repeat (10) @(negedge clk);
    endRun(); waitStopped(20);
    chk(stopped && wrCount == w0, "R10", "stop while waiting", wrCount - w0, 0);
    expQ.delete();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule